// File: doc/BRIEF.md
# Interrupt Level Arbiter and Context Sequencer

This block keeps one 3-bit priority level for each interrupt vector and decides which pending request may interrupt the processor. A level of 7 means the vector has nothing pending. Smaller numbers are more urgent. A request wins only if its level is numerically below the level field held in the processor status word. When several requests qualify, the lowest vector number is chosen.

When the take strobe is accepted, the block saves the processor context onto the system stack over a 16-bit memory port. It then raises the status word to the accepted level and reads a 24-bit handler address from a vector table at the top of the address space.

When the return strobe is accepted, the block first checks whether any request is outstanding. If one is, it reads the saved status word at the stack top without moving the pointer. If a pending request beats the level in that saved word, the block goes straight to that handler and leaves the saved context on the stack. Otherwise it pops the six saved words and restores every register. Instruction decode and arithmetic are done elsewhere. The block only receives the live register values and hands back the updated ones.

Top module: `irq_ctx_seq`

## Requirements
- R1: After synchronous reset, busy, seq_done and mem_req are low, pend_cnt is 0, every vector level is 7, and all register outputs are zero.
- R2: A set request writes set_lvl into the level of vector set_vec, and a clear request writes 7. A level of 7 means nothing is pending. When a set and a clear name the same vector in the same cycle, the clear wins.
- R3: pend_cnt always equals the number of vectors whose level is below 7. It changes only when a set moves a level across 7, or when a clear hits a vector whose level is below 7. Setting an already-pending vector to another level below 7 leaves the count as it is.
- R4: A take strobe is accepted only if some level is numerically below ps_in[15:13]. Among the qualifying vectors the lowest vector number wins. An equal level does not qualify. A take strobe with no qualifying vector is ignored: busy stays low and no memory access starts.
- R5: Entry writes six words to byte address {ssb_in, pointer}. The pointer is decremented by 2 before each write. The words go in this order: acc[31:16], acc[15:0], {dpr,adb}, {dtb,pcb}, pc, ps. After entry, ssp_out equals ssp_in minus 12.
- R6: After an entry or a chained dispatch, ps_out[15:13] holds the accepted level and ps_out[5] (the system-stack select flag) is set. All other bits are kept from the source status word.
- R7: The handler for vector n is read from byte address 0xFFFFFC - 4n. The word at that address becomes pc_out, and the low byte of the word at that address + 2 becomes pcb_out.
- R8: A return strobe while pend_cnt is nonzero reads the word at {ssb_in, ssp_in} without changing the pointer. If a pending level is below bits 15:13 of that word, ps_out takes that word with the new level and flag applied, the winning vector is dispatched as in R7, and ssp_out stays equal to ssp_in.
- R9: Otherwise a return reads six words, incrementing the pointer by 2 after each read. The words restore, in this order: ps, pc, {dtb,pcb}, {dpr,adb}, acc[15:0], acc[31:16]. After the return, ssp_out equals ssp_in plus 12.
- R10: While mem_req is high and mem_ready is low, mem_addr, mem_we and mem_wdata stay stable. Each access completes on exactly one cycle in which mem_ready is high.
- R11: busy rises only in the cycle after an accepted strobe and stays high until the sequence ends. seq_done pulses for one cycle when busy has dropped. Take and return strobes that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_en | input | 1 | Set request strobe |
| set_vec | input | VEC_W | Vector to set |
| set_lvl | input | 3 | Level to write |
| clr_en | input | 1 | Clear request strobe |
| clr_vec | input | VEC_W | Vector to clear |
| take_stb | input | 1 | Begin interrupt entry |
| ret_stb | input | 1 | Begin interrupt return |
| acc_in | input | 32 | Live accumulator |
| dpr_in | input | 8 | Live direct page register |
| adb_in | input | 8 | Live additional data bank |
| dtb_in | input | 8 | Live data bank |
| pcb_in | input | 8 | Live program bank |
| pc_in | input | 16 | Live program counter |
| ps_in | input | 16 | Live status word |
| ssp_in | input | 16 | Live system stack pointer |
| ssb_in | input | 8 | Live system stack bank |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| acc_out | output | 32 | Updated accumulator |
| dpr_out | output | 8 | Updated direct page register |
| adb_out | output | 8 | Updated additional data bank |
| dtb_out | output | 8 | Updated data bank |
| pcb_out | output | 8 | Updated program bank |
| pc_out | output | 16 | Updated program counter |
| ps_out | output | 16 | Updated status word |
| ssp_out | output | 16 | Updated system stack pointer |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle completion pulse |
| pend_cnt | output | CNT_W | Number of pending vectors |

## Verification
A set or clear changes the levels and pend_cnt at the next rising edge, so the bench reads pend_cnt at the falling edge that follows the strobe cycle. A strobe is accepted at the edge where it is high, so busy, or its absence for an ignored strobe, is checked at the next falling edge. Register outputs are final only when seq_done pulses. The bench's memory grants each access one cycle after the request, so an entry takes sixteen cycles, and all register and stack-image checks wait for that pulse and then sample at the falling edge.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

    localparam int          LVL_W     = 3;
    localparam logic [2:0]  LVL_NONE  = 3'd7;
    localparam int          S_BIT     = 5;
    localparam logic [2:0]  CTX_LAST  = 3'd5;
    localparam logic [23:0] VEC_TOP   = 24'hFFFFFC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC_PC,
        ST_VEC_BANK,
        ST_PEEK,
        ST_POP
    } seq_state_e;

    typedef struct packed {
        logic [31:0] acc;
        logic [7:0]  dpr;
        logic [7:0]  adb;
        logic [7:0]  dtb;
        logic [7:0]  pcb;
        logic [15:0] pc;
        logic [15:0] ps;
    } ctx_t;

    // Status word after acceptance: new level on top, stack flag forced on.
    function automatic logic [15:0] ps_enter(logic [15:0] ps, logic [2:0] lvl);
        logic [15:0] p;
        p        = {lvl, ps[12:0]};
        p[S_BIT] = 1'b1;
        return p;
    endfunction

    // Word written at push step idx (0 first).
    function automatic logic [15:0] push_word(ctx_t c, logic [2:0] idx);
        case (idx)
            3'd0:    return c.acc[31:16];
            3'd1:    return c.acc[15:0];
            3'd2:    return {c.dpr, c.adb};
            3'd3:    return {c.dtb, c.pcb};
            3'd4:    return c.pc;
            default: return c.ps;
        endcase
    endfunction

endpackage

// File: rtl/irq_level_table.sv
module irq_level_table
    import irq_ctx_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VEC_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_en,
    input  logic [VEC_W-1:0]         set_vec,
    input  logic [LVL_W-1:0]         set_lvl,
    input  logic                     clr_en,
    input  logic [VEC_W-1:0]         clr_vec,
    output logic [NUM_VEC*LVL_W-1:0] lvl_flat,
    output logic [NUM_VEC-1:0]       pend_mask,
    output logic [CNT_W-1:0]         pend_cnt
);

    localparam logic [VEC_W:0] NV = NUM_VEC[VEC_W:0];

    logic [LVL_W-1:0] lvl_q [NUM_VEC];
    logic             set_ok, clr_ok, set_eff;
    logic             inc_set, dec_set, dec_clr;
    logic [CNT_W-1:0] cnt_q;

    assign set_ok  = set_en && ({1'b0, set_vec} < NV);
    assign clr_ok  = clr_en && ({1'b0, clr_vec} < NV);
    // A clear aimed at the same vector overrides the set.
    assign set_eff = set_ok && !(clr_ok && (clr_vec == set_vec));

    genvar g;
    generate
        for (g = 0; g < NUM_VEC; g++) begin : g_vec
            always_ff @(posedge clk) begin
                if (rst)
                    lvl_q[g] <= LVL_NONE;
                else if (clr_ok && (clr_vec == VEC_W'(g)))
                    lvl_q[g] <= LVL_NONE;
                else if (set_eff && (set_vec == VEC_W'(g)))
                    lvl_q[g] <= set_lvl;
            end
            assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q[g];
            assign pend_mask[g]               = (lvl_q[g] != LVL_NONE);
        end
    endgenerate

    always_comb begin
        inc_set = 1'b0;
        dec_set = 1'b0;
        dec_clr = 1'b0;
        if (set_eff) begin
            inc_set = (lvl_q[set_vec] == LVL_NONE) && (set_lvl != LVL_NONE);
            dec_set = (lvl_q[set_vec] != LVL_NONE) && (set_lvl == LVL_NONE);
        end
        if (clr_ok)
            dec_clr = (lvl_q[clr_vec] != LVL_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(inc_set) - CNT_W'(dec_set) - CNT_W'(dec_clr);
    end

    assign pend_cnt = cnt_q;

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_ctx_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VEC_W   = 3
) (
    input  logic [NUM_VEC*LVL_W-1:0] lvl_flat,
    input  logic [LVL_W-1:0]         threshold,
    output logic                     found,
    output logic [VEC_W-1:0]         win_vec,
    output logic [LVL_W-1:0]         win_lvl
);

    // Scan from the top so the lowest qualifying index is the last writer.
    always_comb begin
        found   = 1'b0;
        win_vec = '0;
        win_lvl = LVL_NONE;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (lvl_flat[i*LVL_W +: LVL_W] < threshold) begin
                found   = 1'b1;
                win_vec = VEC_W'(i);
                win_lvl = lvl_flat[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/irq_stack_fsm.sv
module irq_stack_fsm
    import irq_ctx_pkg::*;
#(
    parameter int VEC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_stb,
    input  logic             ret_stb,
    input  logic             found,
    input  logic [VEC_W-1:0] win_vec,
    input  logic [LVL_W-1:0] win_lvl,
    input  logic             pend_any,
    input  ctx_t             ctx_in,
    input  logic [15:0]      ssp_in,
    input  logic [7:0]       ssb_in,
    output logic             mem_req,
    output logic             mem_we,
    output logic [23:0]      mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    input  logic             mem_ready,
    output ctx_t             ctx_out,
    output logic [15:0]      ssp_out,
    output logic             peeking,
    output logic             busy,
    output logic             done
);

    seq_state_e       state_q;
    logic [2:0]       idx_q;
    ctx_t             ctx_q;
    logic [15:0]      ssp_q;
    logic [7:0]       ssb_q;
    logic [VEC_W-1:0] vec_q;
    logic [LVL_W-1:0] lvl_q;
    logic             done_q;
    logic [23:0]      vec_addr;

    assign vec_addr  = VEC_TOP - (24'(vec_q) << 2);
    assign mem_req   = (state_q != ST_IDLE);
    assign mem_we    = (state_q == ST_PUSH);
    assign mem_wdata = push_word(ctx_q, idx_q);
    assign peeking   = (state_q == ST_PEEK);
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign ctx_out   = ctx_q;
    assign ssp_out   = ssp_q;

    always_comb begin
        case (state_q)
            ST_PUSH:     mem_addr = {ssb_q, ssp_q - 16'd2};
            ST_VEC_PC:   mem_addr = vec_addr;
            ST_VEC_BANK: mem_addr = vec_addr + 24'd2;
            default:     mem_addr = {ssb_q, ssp_q};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ctx_q   <= '0;
            ssp_q   <= '0;
            ssb_q   <= '0;
            vec_q   <= '0;
            lvl_q   <= LVL_NONE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (take_stb && found) begin
                        ctx_q   <= ctx_in;
                        ssp_q   <= ssp_in;
                        ssb_q   <= ssb_in;
                        vec_q   <= win_vec;
                        lvl_q   <= win_lvl;
                        state_q <= ST_PUSH;
                    end else if (ret_stb) begin
                        ctx_q   <= ctx_in;
                        ssp_q   <= ssp_in;
                        ssb_q   <= ssb_in;
                        state_q <= pend_any ? ST_PEEK : ST_POP;
                    end
                end
                ST_PUSH: if (mem_ready) begin
                    ssp_q <= ssp_q - 16'd2;
                    if (idx_q == CTX_LAST) begin
                        ctx_q.ps <= ps_enter(ctx_q.ps, lvl_q);
                        state_q  <= ST_VEC_PC;
                    end else begin
                        idx_q <= idx_q + 3'd1;
                    end
                end
                ST_VEC_PC: if (mem_ready) begin
                    ctx_q.pc <= mem_rdata;
                    state_q  <= ST_VEC_BANK;
                end
                ST_VEC_BANK: if (mem_ready) begin
                    ctx_q.pcb <= mem_rdata[7:0];
                    state_q   <= ST_IDLE;
                    done_q    <= 1'b1;
                end
                ST_PEEK: if (mem_ready) begin
                    if (found) begin
                        ctx_q.ps <= ps_enter(mem_rdata, win_lvl);
                        vec_q    <= win_vec;
                        state_q  <= ST_VEC_PC;
                    end else begin
                        idx_q   <= '0;
                        state_q <= ST_POP;
                    end
                end
                ST_POP: if (mem_ready) begin
                    ssp_q <= ssp_q + 16'd2;
                    case (idx_q)
                        3'd0:    ctx_q.ps          <= mem_rdata;
                        3'd1:    ctx_q.pc          <= mem_rdata;
                        3'd2:    {ctx_q.dtb, ctx_q.pcb} <= mem_rdata;
                        3'd3:    {ctx_q.dpr, ctx_q.adb} <= mem_rdata;
                        3'd4:    ctx_q.acc[15:0]   <= mem_rdata;
                        default: ctx_q.acc[31:16]  <= mem_rdata;
                    endcase
                    if (idx_q == CTX_LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 3'd1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter  int NUM_VEC = 8,
    localparam int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int CNT_W   = $clog2(NUM_VEC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [VEC_W-1:0]  set_vec,
    input  logic [2:0]        set_lvl,
    input  logic              clr_en,
    input  logic [VEC_W-1:0]  clr_vec,
    input  logic              take_stb,
    input  logic              ret_stb,
    input  logic [31:0]       acc_in,
    input  logic [7:0]        dpr_in,
    input  logic [7:0]        adb_in,
    input  logic [7:0]        dtb_in,
    input  logic [7:0]        pcb_in,
    input  logic [15:0]       pc_in,
    input  logic [15:0]       ps_in,
    input  logic [15:0]       ssp_in,
    input  logic [7:0]        ssb_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [23:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ready,
    output logic [31:0]       acc_out,
    output logic [7:0]        dpr_out,
    output logic [7:0]        adb_out,
    output logic [7:0]        dtb_out,
    output logic [7:0]        pcb_out,
    output logic [15:0]       pc_out,
    output logic [15:0]       ps_out,
    output logic [15:0]       ssp_out,
    output logic              busy,
    output logic              seq_done,
    output logic [CNT_W-1:0]  pend_cnt
);

    logic [NUM_VEC*LVL_W-1:0] lvl_flat;
    logic [NUM_VEC-1:0]       pend_mask;
    logic [LVL_W-1:0]         threshold;
    logic                     found, peeking;
    logic [VEC_W-1:0]         win_vec;
    logic [LVL_W-1:0]         win_lvl;
    ctx_t                     ctx_live, ctx_cur;

    assign ctx_live = '{acc: acc_in, dpr: dpr_in, adb: adb_in, dtb: dtb_in,
                        pcb: pcb_in, pc: pc_in, ps: ps_in};

    // Entry compares against the live level, a chained return against the saved one.
    assign threshold = peeking ? mem_rdata[15:13] : ps_in[15:13];

    irq_level_table #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .CNT_W(CNT_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .set_en    (set_en),
        .set_vec   (set_vec),
        .set_lvl   (set_lvl),
        .clr_en    (clr_en),
        .clr_vec   (clr_vec),
        .lvl_flat  (lvl_flat),
        .pend_mask (pend_mask),
        .pend_cnt  (pend_cnt)
    );

    irq_pick #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pick (
        .lvl_flat  (lvl_flat),
        .threshold (threshold),
        .found     (found),
        .win_vec   (win_vec),
        .win_lvl   (win_lvl)
    );

    irq_stack_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .take_stb  (take_stb),
        .ret_stb   (ret_stb),
        .found     (found),
        .win_vec   (win_vec),
        .win_lvl   (win_lvl),
        .pend_any  (|pend_mask),
        .ctx_in    (ctx_live),
        .ssp_in    (ssp_in),
        .ssb_in    (ssb_in),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .ctx_out   (ctx_cur),
        .ssp_out   (ssp_out),
        .peeking   (peeking),
        .busy      (busy),
        .done      (seq_done)
    );

    assign acc_out = ctx_cur.acc;
    assign dpr_out = ctx_cur.dpr;
    assign adb_out = ctx_cur.adb;
    assign dtb_out = ctx_cur.dtb;
    assign pcb_out = ctx_cur.pcb;
    assign pc_out  = ctx_cur.pc;
    assign ps_out  = ctx_cur.ps;

endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk #(
    parameter int NUM_VEC = 8,
    parameter int CNT_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               mem_req,
    input logic               mem_ready,
    input logic               mem_we,
    input logic [23:0]        mem_addr,
    input logic [15:0]        mem_wdata,
    input logic               busy,
    input logic               seq_done,
    input logic               take_stb,
    input logic               ret_stb,
    input logic [15:0]        ssp_out,
    input logic [CNT_W-1:0]   pend_cnt,
    input logic [NUM_VEC-1:0] pend_mask
);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> !busy);

    // R11
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(take_stb || ret_stb));

    // R5
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_req && mem_we && mem_ready) |=>
            (ssp_out == $past(ssp_out) - 16'd2));

    // R3
    pend_count_chk: assert property (@(posedge clk) disable iff (rst)
        int'(pend_cnt) == $countones(pend_mask));

endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .seq_done  (seq_done),
    .take_stb  (take_stb),
    .ret_stb   (ret_stb),
    .ssp_out   (ssp_out),
    .pend_cnt  (pend_cnt),
    .pend_mask (pend_mask)
);

// File: tb/irq_ctx_seq_bench.sv
module irq_ctx_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_en = 1'b0, clr_en = 1'b0, take_stb = 1'b0, ret_stb = 1'b0;
    logic [2:0]  set_vec = '0, set_lvl = '0, clr_vec = '0;
    logic [31:0] acc_in = 32'hA1B2C3D4;
    logic [7:0]  dpr_in = 8'h11, adb_in = 8'h22, dtb_in = 8'h33, pcb_in = 8'h44;
    logic [15:0] pc_in = 16'h5566, ps_in = 16'hE055, ssp_in = 16'h0800;
    logic [7:0]  ssb_in = 8'hE0;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic [31:0] acc_out;
    logic [7:0]  dpr_out, adb_out, dtb_out, pcb_out;
    logic [15:0] pc_out, ps_out, ssp_out;
    logic        busy, seq_done;
    logic [3:0]  pend_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] mem [logic [23:0]];

    irq_ctx_seq #(.NUM_VEC(8)) u_irq_ctx_seq (
        .clk(clk), .rst(rst), .set_en(set_en), .set_vec(set_vec), .set_lvl(set_lvl),
        .clr_en(clr_en), .clr_vec(clr_vec), .take_stb(take_stb), .ret_stb(ret_stb),
        .acc_in(acc_in), .dpr_in(dpr_in), .adb_in(adb_in), .dtb_in(dtb_in),
        .pcb_in(pcb_in), .pc_in(pc_in), .ps_in(ps_in), .ssp_in(ssp_in), .ssb_in(ssb_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .acc_out(acc_out),
        .dpr_out(dpr_out), .adb_out(adb_out), .dtb_out(dtb_out), .pcb_out(pcb_out),
        .pc_out(pc_out), .ps_out(ps_out), .ssp_out(ssp_out), .busy(busy),
        .seq_done(seq_done), .pend_cnt(pend_cnt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] rd(logic [23:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    // Memory model: grants each access one cycle after the request, commits writes at the grant.
    always @(negedge clk) begin
        if (mem_req && !mem_ready) begin
            if (mem_we) mem[mem_addr] = mem_wdata;
            mem_rdata <= rd(mem_addr);
            mem_ready <= 1'b1;
        end else begin
            mem_ready <= 1'b0;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_req(logic [2:0] v, logic [2:0] l);
        @(negedge clk); set_en = 1'b1; set_vec = v; set_lvl = l;
        @(negedge clk); set_en = 1'b0;
    endtask

    task automatic clr_req(logic [2:0] v);
        @(negedge clk); clr_en = 1'b1; clr_vec = v;
        @(negedge clk); clr_en = 1'b0;
    endtask

    task automatic set_and_clr(logic [2:0] sv, logic [2:0] sl, logic [2:0] cv);
        @(negedge clk); set_en = 1'b1; set_vec = sv; set_lvl = sl; clr_en = 1'b1; clr_vec = cv;
        @(negedge clk); set_en = 1'b0; clr_en = 1'b0;
    endtask

    task automatic pulse_take();
        @(negedge clk); take_stb = 1'b1;
        @(negedge clk); take_stb = 1'b0;
    endtask

    task automatic pulse_ret();
        @(negedge clk); ret_stb = 1'b1;
        @(negedge clk); ret_stb = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (seq_done) return;
        end
        chk("R11 done never seen", 32'd0, 32'd1);
    endtask

    // {a_vec, a_lvl, b_vec, b_lvl, cpu_lvl, hit, win_vec}
    localparam logic [18:0] TBL [5] = '{
        {3'd5, 3'd1, 3'd2, 3'd4, 3'd7, 1'b1, 3'd2},
        {3'd6, 3'd3, 3'd1, 3'd5, 3'd4, 1'b1, 3'd6},
        {3'd0, 3'd4, 3'd7, 3'd6, 3'd4, 1'b0, 3'd0},
        {3'd0, 3'd0, 3'd7, 3'd6, 3'd1, 1'b1, 3'd0},
        {3'd7, 3'd2, 3'd4, 3'd7, 3'd3, 1'b1, 3'd7}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int n = 0; n < 8; n++) begin
            mem[24'hFFFFFC - 24'(n * 4)]     = 16'h1000 + 16'(n);
            mem[24'hFFFFFC - 24'(n * 4) + 2] = 16'h0040 + 16'(n);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 seq_done", 32'(seq_done), 32'd0);
        chk("R1 pend_cnt", 32'(pend_cnt), 32'd0);
        chk("R1 ps_out", 32'(ps_out), 32'd0);
        chk("R1 ssp_out", 32'(ssp_out), 32'd0);

        // Table walk: entry arbitration, stacking and vector fetch
        for (int r = 0; r < 5; r++) begin
            logic [18:0] row;
            logic [2:0]  av, al, bv, bl, cpu, wv, wl;
            logic        hit;
            row = TBL[r];
            {av, al, bv, bl, cpu, hit, wv} = row;
            wl = (wv == av) ? al : bl;
            ps_in  = {cpu, 13'h0055};
            ssp_in = 16'h0800;
            set_req(av, al);
            set_req(bv, bl);
            chk("R3 count after sets", 32'(pend_cnt), 32'(al != 3'd7) + 32'(bl != 3'd7));
            pulse_take();
            if (hit) begin
                chk("R11 busy after take", 32'(busy), 32'd1);
                wait_done();
                chk("R6 ps level and stack flag", 32'(ps_out), 32'({wl, 13'h0075}));
                chk("R4 R7 handler pc", 32'(pc_out), 32'h1000 + 32'(wv));
                chk("R7 handler bank", 32'(pcb_out), 32'h40 + 32'(wv));
                chk("R5 ssp after entry", 32'(ssp_out), 32'h07F4);
                chk("R5 acc high pushed first", 32'(rd(24'hE007FE)), 32'hA1B2);
                chk("R5 bank pair slot", 32'(rd(24'hE007F8)), 32'h3344);
                chk("R5 ps pushed last", 32'(rd(24'hE007F4)), 32'(ps_in));
            end else begin
                chk("R4 ignored take busy", 32'(busy), 32'd0);
                chk("R4 ignored take mem_req", 32'(mem_req), 32'd0);
            end
            clr_req(av);
            clr_req(bv);
            chk("R2 count after clears", 32'(pend_cnt), 32'd0);
        end

        // R9 plain return, nothing pending
        mem[24'hE007F4] = 16'h2003; mem[24'hE007F6] = 16'h1234;
        mem[24'hE007F8] = 16'h5566; mem[24'hE007FA] = 16'h7788;
        mem[24'hE007FC] = 16'h9ABC; mem[24'hE007FE] = 16'hDEF0;
        ssp_in = 16'h07F4;
        pulse_ret();
        wait_done();
        chk("R9 ps", 32'(ps_out), 32'h2003);
        chk("R9 pc", 32'(pc_out), 32'h1234);
        chk("R9 dtb", 32'(dtb_out), 32'h55);
        chk("R9 pcb", 32'(pcb_out), 32'h66);
        chk("R9 dpr", 32'(dpr_out), 32'h77);
        chk("R9 adb", 32'(adb_out), 32'h88);
        chk("R9 acc", acc_out, 32'hDEF09ABC);
        chk("R9 ssp", 32'(ssp_out), 32'h0800);

        // R8 pending request that does not beat the saved level -> full pop
        set_req(3'd3, 3'd5);
        pulse_ret();
        wait_done();
        chk("R8 no chain ps", 32'(ps_out), 32'h2003);
        chk("R8 no chain ssp", 32'(ssp_out), 32'h0800);

        // R8 chained dispatch: saved level 6 beaten by level 5, live level 0 ignored
        mem[24'hE007F4] = 16'hC003;
        ps_in = 16'h0000;
        pulse_ret();
        wait_done();
        chk("R8 chain ps", 32'(ps_out), 32'hA023);
        chk("R8 chain pc", 32'(pc_out), 32'h1003);
        chk("R8 chain pcb", 32'(pcb_out), 32'h43);
        chk("R8 chain ssp unchanged", 32'(ssp_out), 32'h07F4);
        chk("R8 chain acc untouched", acc_out, 32'hA1B2C3D4);
        clr_req(3'd3);

        // R11 strobes during busy are ignored
        ps_in = 16'hE055; ssp_in = 16'h0800;
        set_req(3'd2, 3'd1);
        pulse_take();
        pulse_ret();
        pulse_take();
        wait_done();
        chk("R11 single entry ssp", 32'(ssp_out), 32'h07F4);
        chk("R11 single entry ps", 32'(ps_out), 32'h2075);
        @(negedge clk);
        chk("R11 done is one pulse", 32'(seq_done), 32'd0);
        chk("R11 no late sequence", 32'(busy), 32'd0);
        clr_req(3'd2);

        // R2 / R3 corner cases on the level table
        set_req(3'd4, 3'd2);
        chk("R3 first set", 32'(pend_cnt), 32'd1);
        set_req(3'd4, 3'd4);
        chk("R3 relevel keeps count", 32'(pend_cnt), 32'd1);
        set_and_clr(3'd4, 3'd3, 3'd4);
        chk("R2 clear wins", 32'(pend_cnt), 32'd0);
        set_and_clr(3'd5, 3'd1, 3'd4);
        chk("R3 set plus idle clear", 32'(pend_cnt), 32'd1);
        clr_req(3'd5);
        clr_req(3'd5);
        chk("R3 clear of idle vector", 32'(pend_cnt), 32'd0);
        pulse_take();
        chk("R2 level 7 not pending", 32'(busy), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule